// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching two table entries from memory, one after the other. A requester presents a virtual address and an access type. The walker reads the directory entry selected by the upper address bits. The directory base comes from a base-register input that is sampled when the request is taken. If that entry is marked present, the walker reads the second-level entry that the entry points to. It then returns the frame number joined to the untouched in-page offset, or a fault.

Each translation costs two memory reads, or one when the directory entry is absent. Reads go out on a request port with a valid/ready handshake. Data comes back on a separate response valid. Any number of stall or latency cycles is tolerated. The result stays on the output until the requester acknowledges it, and no new request is taken while a walk is in flight.

Top module: `pw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `mem_req_valid` is 0 and `rsp_valid` is 0.
- R2: The first read goes to `ptbr + vaddr[31:22]*4`, taken modulo 2^32. `ptbr` is sampled in the cycle the request is accepted, so later changes to it have no effect on that walk.
- R3: When the directory entry has bit 0 set, the second read goes to `{dir_entry[31:12], vaddr[21:12], 2'b00}`.
- R4: When both entries have bit 0 set, the response carries `rsp_fault` = 0 and `rsp_paddr` = `{pt_entry[31:12], vaddr[11:0]}`.
- R5: A directory entry with bit 0 clear ends the walk with `rsp_fault` = 1 and `rsp_paddr` = 0, and no second read is issued.
- R6: A second-level entry with bit 0 clear ends the walk with `rsp_fault` = 1 and `rsp_paddr` = 0.
- R7: A memory read request, once raised, keeps `mem_req_valid` high and `mem_req_addr` unchanged until `mem_req_ready` accepts it. Any number of stall cycles and any response latency are accepted.
- R8: `req_ready` is high only while idle, so requests presented during a walk are ignored. The response holds `rsp_valid`, `rsp_paddr` and `rsp_fault` until `rsp_ready` is seen, after which the walker is idle again.
- R9: `rsp_write` returns the access type given with the accepted request, and the access type has no effect on either read address or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access type (1 = store) |
| ptbr | input | 32 | Byte address of the directory |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word read from memory |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Page fault |
| rsp_write | output | 1 | Access type of the translated request |

## Verification
On every cycle, the assertions check the port protocol. A stalled memory request must keep its address. A pending result must stay frozen until acknowledged. No request may be taken while a result waits. A memory read and a result are never present together, and a fault always reports a zero address. Whether each read address comes from the right index and base, and whether the final address is built from the right frame and offset, is shown only by the bench's scenarios. Those scenarios compare against its own model across random addresses, entries, stalls and latencies, and include directed faults and base wrap-around.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    PW_IDLE     = 2'd0,
    PW_READ_DIR = 2'd1,
    PW_READ_PT  = 2'd2,
    PW_DONE     = 2'd3
  } pw_state_e;
endpackage

// File: rtl/pw_addr_split.sv
module pw_addr_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] vaddr,
  output logic [IDX_W-1:0]  dir_idx,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic [OFF_W-1:0]  offset
);
  // directory index sits in the topmost bits, table index just above the offset
  assign dir_idx = vaddr[ADDR_W-1 -: IDX_W];
  assign tbl_idx = vaddr[OFF_W +: IDX_W];
  assign offset  = vaddr[OFF_W-1:0];
endmodule

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int ESH    = 2
) (
  input  logic [ADDR_W-1:0]       base,
  input  logic [IDX_W-1:0]        dir_idx,
  input  logic [IDX_W-1:0]        tbl_idx,
  input  logic [ADDR_W-OFF_W-1:0] frame,
  output logic [ADDR_W-1:0]       dir_addr,
  output logic [ADDR_W-1:0]       pt_addr
);
  localparam int IDX_BYTES_W = IDX_W + ESH;

  logic [ADDR_W-1:0] dir_ofs;
  logic [ADDR_W-1:0] tbl_ofs;
  logic [ADDR_W-1:0] frame_base;

  assign dir_ofs    = ADDR_W'({dir_idx, {ESH{1'b0}}});
  assign tbl_ofs    = ADDR_W'({tbl_idx, {ESH{1'b0}}});
  assign frame_base = {frame, {OFF_W{1'b0}}};

  assign dir_addr = base + dir_ofs;
  assign pt_addr  = frame_base + tbl_ofs;

  initial begin
    assert (IDX_BYTES_W <= OFF_W)
      else $error("table index does not fit within one page");
  end
endmodule

// File: rtl/pw_walk_fsm.sv
module pw_walk_fsm
  import pw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int VALID_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic [ADDR_W-1:0] vaddr_q,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [ADDR_W-1:0] pt_addr,
  input  logic [OFF_W-1:0]  offset,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              rsp_write
);
  pw_state_e state;
  logic      entry_ok;
  logic      rsp_take;
  logic      unused_rsv;

  assign entry_ok   = mem_rsp_data[VALID_BIT];
  // a response counts only once the read request has been accepted
  assign rsp_take   = mem_rsp_valid && !mem_req_valid;
  assign req_ready  = (state == PW_IDLE);
  assign unused_rsv = ^mem_rsp_data[OFF_W-1:VALID_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= PW_IDLE;
      vaddr_q       <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_fault     <= 1'b0;
      rsp_write     <= 1'b0;
    end else begin
      case (state)
        PW_IDLE: begin
          if (req_valid) begin
            vaddr_q       <= req_vaddr;
            rsp_write     <= req_write;
            mem_req_addr  <= dir_addr;
            mem_req_valid <= 1'b1;
            state         <= PW_READ_DIR;
          end
        end
        PW_READ_DIR: begin
          if (mem_req_valid) begin
            if (mem_req_ready) mem_req_valid <= 1'b0;
          end else if (rsp_take) begin
            if (entry_ok) begin
              mem_req_addr  <= pt_addr;
              mem_req_valid <= 1'b1;
              state         <= PW_READ_PT;
            end else begin
              rsp_paddr <= '0;
              rsp_fault <= 1'b1;
              rsp_valid <= 1'b1;
              state     <= PW_DONE;
            end
          end
        end
        PW_READ_PT: begin
          if (mem_req_valid) begin
            if (mem_req_ready) mem_req_valid <= 1'b0;
          end else if (rsp_take) begin
            if (entry_ok) begin
              rsp_paddr <= {mem_rsp_data[ADDR_W-1:OFF_W], offset};
              rsp_fault <= 1'b0;
            end else begin
              rsp_paddr <= '0;
              rsp_fault <= 1'b1;
            end
            rsp_valid <= 1'b1;
            state     <= PW_DONE;
          end
        end
        PW_DONE: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state     <= PW_IDLE;
          end
        end
        default: state <= PW_IDLE;
      endcase
    end
  end

  assert_mem_hold_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  assert_busy_no_accept_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  assert_single_activity_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !rsp_valid);
endmodule

// File: rtl/pw_walker.sv
module pw_walker #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int IDX_W     = 10,
  parameter int ESH       = 2,
  parameter int VALID_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] ptbr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              rsp_write
);
  localparam int FRAME_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] vaddr_q;
  logic [ADDR_W-1:0] walk_va;
  logic [IDX_W-1:0]  dir_idx;
  logic [IDX_W-1:0]  tbl_idx;
  logic [OFF_W-1:0]  offset;
  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] pt_addr;

  // while idle the live request drives the split, afterwards the latched one
  assign walk_va = req_ready ? req_vaddr : vaddr_q;

  pw_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_split (
    .vaddr   (walk_va),
    .dir_idx (dir_idx),
    .tbl_idx (tbl_idx),
    .offset  (offset)
  );

  pw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ESH(ESH)) i_eaddr (
    .base     (ptbr),
    .dir_idx  (dir_idx),
    .tbl_idx  (tbl_idx),
    .frame    (mem_rsp_data[ADDR_W-1 -: FRAME_W]),
    .dir_addr (dir_addr),
    .pt_addr  (pt_addr)
  );

  pw_walk_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .VALID_BIT(VALID_BIT)) i_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .vaddr_q       (vaddr_q),
    .dir_addr      (dir_addr),
    .pt_addr       (pt_addr),
    .offset        (offset),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .rsp_write     (rsp_write)
  );
endmodule

// File: tb/test_pw_walker.sv
module test_pw_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [31:0] ptbr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        rsp_write;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pw_walker i_pw_walker (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .ptbr(ptbr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_write(rsp_write)
  );

  function automatic logic [31:0] exp_dir(input logic [31:0] base, input logic [31:0] va);
    return base + {20'd0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] exp_pt(input logic [31:0] de, input logic [31:0] va);
    return {de[31:12], va[21:12], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic serve(input logic [31:0] addr, input logic [31:0] data,
                       input string req, input int stall, input int lat);
    int t = 0;
    while (!mem_req_valid && t < 50) begin
      @(negedge clk);
      t++;
    end
    chk(mem_req_valid, req, "read issued", {31'd0, mem_req_valid}, 32'd1);
    chk(mem_req_addr == addr, req, "read address", mem_req_addr, addr);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == addr, "R7", "stalled read held",
          mem_req_addr, addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int i = 0; i < lat; i++) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = $urandom;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input logic wr,
                      input logic [31:0] de, input logic [31:0] pte,
                      input int stall, input int lat, input bit hold_req);
    logic        fault;
    logic [31:0] paddr;
    string       tag;
    int          t;
    int          hold;
    @(negedge clk);
    chk(req_ready, "R8", "idle before request", {31'd0, req_ready}, 32'd1);
    req_vaddr = va; ptbr = base; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    if (hold_req) begin
      req_vaddr = ~va; req_write = ~wr;
    end else begin
      req_valid = 1'b0;
    end
    ptbr = $urandom;  // R2: later base changes must not matter
    chk(!req_ready, "R8", "busy after accept", {31'd0, req_ready}, 32'd0);
    serve(exp_dir(base, va), de, "R2", stall, lat);
    if (de[0]) begin
      serve(exp_pt(de, va), pte, "R3", stall, lat);
    end else begin
      for (int i = 0; i < 3; i++) begin
        chk(!mem_req_valid, "R5", "no second read", {31'd0, mem_req_valid}, 32'd0);
        @(negedge clk);
      end
    end
    t = 0;
    while (!rsp_valid && t < 50) begin
      @(negedge clk);
      t++;
    end
    fault = !de[0] || !pte[0];
    paddr = fault ? 32'd0 : {pte[31:12], va[11:0]};
    tag = !de[0] ? "R5" : (!pte[0] ? "R6" : "R4");
    chk(rsp_valid, tag, "response present", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_paddr == paddr, tag, "physical address", rsp_paddr, paddr);
    chk(rsp_fault == fault, tag, "fault flag", {31'd0, rsp_fault}, {31'd0, fault});
    chk(rsp_write == wr, "R9", "access type echo", {31'd0, rsp_write}, {31'd0, wr});
    hold = $urandom % 3;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == paddr && !req_ready, "R8", "result held",
          rsp_paddr, paddr);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R8", "idle after acknowledge",
        {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !rsp_valid, "R1", "reset state",
        {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'd4);

    // directed corner cases
    walk(32'h0040_3abc, 32'h0010_0000, 1'b0, 32'h0002_0001, 32'h0abc_d001, 0, 0, 1'b0);
    walk(32'hffff_ffff, 32'hffff_f800, 1'b1, 32'h1234_5001, 32'hfffff_001, 2, 3, 1'b0);
    walk(32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_1001, 32'h0000_0fff, 1, 0, 1'b0);
    walk(32'h8765_4321, 32'h0020_0000, 1'b1, 32'hffff_fffe, 32'h5555_5001, 0, 2, 1'b0);
    walk(32'h8765_4321, 32'h0020_0000, 1'b0, 32'h0033_3001, 32'h7777_7ffe, 3, 1, 1'b0);
    walk(32'h1357_9bdf, 32'h0030_0000, 1'b0, 32'h0044_4001, 32'h0999_9001, 0, 0, 1'b1);
    walk(32'h1357_9bdf, 32'h0030_0000, 1'b1, 32'h0044_4001, 32'h0999_9001, 4, 4, 1'b1);

    // random walks
    for (int n = 0; n < 150; n++) begin
      logic [31:0] de;
      logic [31:0] pte;
      de  = $urandom;
      pte = $urandom;
      de[0]  = ($urandom % 6) != 0;
      pte[0] = ($urandom % 6) != 0;
      walk($urandom, $urandom, 1'($urandom), de, pte,
           $urandom % 4, $urandom % 4, 1'(($urandom % 4) == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule